// File: doc/BRIEF.md
# Dual-Address DMA Channel Engine

This block is one DMA channel. It copies a block of bytes by reading from a source address and then writing to a destination address over a simple memory-mapped master port. Software loads four registers: source address, destination address, byte count, and a control/status word. The control/status word sets the source and destination access sizes, the increment enables and the request mode. It also holds the start, done, bus-error, busy and launch bits.

A transfer moves max(source size, destination size) bytes. When the destination is wider than the source, the channel performs several reads and then one write. When the source is wider, it performs one read and then several writes. Bytes are kept little-endian in a 32-bit holding register. The channel starts either from a software start bit or from a peripheral request line. It stops when the count reaches zero, when a bus error occurs, or when software aborts it.

Register select: 0 is the source address, 1 is the destination address, and 2 is the byte count. Select 3 is the control/status word, with these bits:

| Bit(s) | Name | Access and meaning |
|---|---|---|
| 0 | go | Write-only; reads as 0 |
| 1 | req_en | Peripheral request mode |
| 2 | auto_off | Clear req_en at terminal count |
| 3 | src_inc | Source address increment |
| 4 | dst_inc | Destination address increment |
| 6:5 | src_size | Source access size |
| 8:7 | dst_size | Destination access size |
| 24 | done | Reads done; writing 1 clears done and aborts |
| 25 | bus_err | Bus error seen |
| 26 | busy | Channel active |
| 27 | launched | A transfer has begun |

Size code 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes.

Top module: `dma_xfer_engine`

## Requirements
- R1: With req_en clear and done clear, a control write with go set starts back-to-back transfers until the count reaches zero. The go bit always reads back as 0.
- R2: A go request is ignored while done is set. No bus access occurs and the count is unchanged.
- R3: After each successful read, the source address advances by the source size in bytes (1, 2 or 4) when src_inc is set. Otherwise it stays unchanged.
- R4: After each successful write, the destination address advances by the destination size in bytes when dst_inc is set. Otherwise it stays unchanged.
- R5: Each successful write lowers the count by the destination size in bytes. When the count reaches zero, done and irq are set. A go request with a zero count sets done without any bus access.
- R6: When the destination is wider than the source, dst/src reads occur before one write. The first byte read lands in the lowest byte of the write data.
- R7: When the source is wider than the destination, one read is followed by src/dst writes. The lowest bytes of the read data are written first.
- R8: With req_en set, each transfer of max(src, dst) bytes starts only when periph_req is high while the channel is idle.
- R9: With auto_off set, req_en reads back 0 once the count reaches zero.
- R10: An error response sets bus_err and done and stops the channel. No further access is issued.
- R11: Writing 1 to done clears done and bus_err and stops an active channel after its outstanding access. irq falls only after a register write.
- R12: m_valid stays high with m_addr, m_write and m_size stable until m_ready. Only one access is outstanding, and m_size is never 3.
- R13: The launched bit is set when a transfer begins. Writing 1 to done clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| periph_req | input | 1 | Peripheral transfer request |
| m_valid | output | 1 | Bus access valid |
| m_write | output | 1 | Bus access is a write |
| m_addr | output | ADDR_W | Bus byte address |
| m_size | output | 2 | Access size code |
| m_wdata | output | 32 | Write data, right-justified |
| m_ready | input | 1 | Access complete |
| m_rdata | input | 32 | Read data, right-justified |
| m_err | input | 1 | Error response with m_ready |
| irq | output | 1 | Level interrupt, equal to done |

## Verification
A register write becomes visible on the next read. The first access appears on m_valid two edges after the go write, and from then on one access can be outstanding at a time. Addresses, the count and the holding register update on the same edge as the m_ready handshake, and irq rises on the edge of the final write handshake. Because the bus latency is randomised, the bench does not count cycles for completion: it waits for irq and then compares registers, access counts and memory against its own model. "Nothing happens" checks (R2, R8, R10, R11) watch fixed windows of 20 to 40 cycles, which is longer than any transfer step.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} phase_e;

  typedef struct packed {
    logic [1:0] dsz;
    logic [1:0] ssz;
    logic       dinc;
    logic       sinc;
    logic       auto_off;
    logic       req_en;
  } ctrl_t;

  function automatic logic [2:0] size_bytes(input logic [1:0] s);
    case (s)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] size_norm(input logic [1:0] s);
    return (s == 2'd3) ? 2'd2 : s;
  endfunction
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step import dma_pkg::*; #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic          inc,
  output logic [AW-1:0] nxt
);
  always_comb nxt = inc ? addr + AW'(size_bytes(size)) : addr;
endmodule

// File: rtl/dma_pack.sv
module dma_pack import dma_pkg::*; #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [1:0]         lane,
  input  logic [1:0]         size,
  input  logic [8*LANES-1:0] rdata,
  output logic [8*LANES-1:0] view
);
  localparam int DW = 8 * LANES;
  logic [DW-1:0] hold_q;
  logic [DW-1:0] shifted;
  logic [2:0]    nb;

  always_comb begin
    shifted = rdata << {lane, 3'b000};
    nb      = size_bytes(size);
    view    = hold_q >> {lane, 3'b000};
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        hold_q[8*i +: 8] <= '0;
      else if (load && (4'(i) >= {2'b00, lane}) && (4'(i) < ({2'b00, lane} + {1'b0, nb})))
        hold_q[8*i +: 8] <= shifted[8*i +: 8];
    end
  end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine import dma_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              periph_req,
  output logic              m_valid,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [1:0]        m_size,
  output logic [31:0]       m_wdata,
  input  logic              m_ready,
  input  logic [31:0]       m_rdata,
  input  logic              m_err,
  output logic              irq
);
  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;
  localparam int B_GO   = 0;
  localparam int B_DONE = 24;

  logic [ADDR_W-1:0] src_q, dst_q, src_nxt, dst_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_dec;
  ctrl_t             ctl_q;
  phase_e            phase_q;
  logic              done_q, berr_q, launch_q, sw_run_q, halt_q;
  logic [2:0]        lane_q, lane_adv, sb, db, nb_rsp;
  logic              launch, rd_ok;
  logic [31:0]       view;

  dma_addr_step #(.AW(ADDR_W)) i_src_step (
    .addr(src_q), .size(m_size), .inc(ctl_q.sinc), .nxt(src_nxt));
  dma_addr_step #(.AW(ADDR_W)) i_dst_step (
    .addr(dst_q), .size(m_size), .inc(ctl_q.dinc), .nxt(dst_nxt));

  assign rd_ok = m_valid && m_ready && !m_err && !m_write && !halt_q;

  dma_pack #(.LANES(4)) i_pack (
    .clk(clk), .rst(rst), .load(rd_ok), .lane(lane_q[1:0]),
    .size(m_size), .rdata(m_rdata), .view(view));

  always_comb begin
    sb       = size_bytes(ctl_q.ssz);
    db       = size_bytes(ctl_q.dsz);
    nb_rsp   = size_bytes(m_size);
    lane_adv = lane_q + nb_rsp;
    cnt_dec  = (cnt_q > CNT_W'(nb_rsp)) ? cnt_q - CNT_W'(nb_rsp) : '0;
    launch   = !done_q && (cnt_q != '0) && (ctl_q.req_en ? periph_req : sw_run_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0; ctl_q <= '0;
      phase_q <= ST_IDLE; lane_q <= '0;
      done_q <= 1'b0; berr_q <= 1'b0; launch_q <= 1'b0;
      sw_run_q <= 1'b0; halt_q <= 1'b0;
      m_valid <= 1'b0; m_write <= 1'b0; m_addr <= '0; m_size <= '0; m_wdata <= '0;
    end else begin
      case (phase_q)
        ST_IDLE: begin
          if (launch) begin
            phase_q  <= ST_RD;
            lane_q   <= '0;
            launch_q <= 1'b1;
          end else if (!ctl_q.req_en && sw_run_q && cnt_q == '0) begin
            done_q   <= 1'b1;
            sw_run_q <= 1'b0;
          end
        end
        default: begin
          if (!m_valid) begin
            if (halt_q) begin
              phase_q <= ST_IDLE;
              halt_q  <= 1'b0;
            end else begin
              m_valid <= 1'b1;
              m_write <= (phase_q == ST_WR);
              m_addr  <= (phase_q == ST_WR) ? dst_q : src_q;
              m_size  <= size_norm((phase_q == ST_WR) ? ctl_q.dsz : ctl_q.ssz);
              m_wdata <= view;
            end
          end else if (m_ready) begin
            m_valid <= 1'b0;
            if (m_err) begin
              berr_q   <= 1'b1;
              done_q   <= 1'b1;
              sw_run_q <= 1'b0;
              halt_q   <= 1'b0;
              phase_q  <= ST_IDLE;
            end else if (halt_q) begin
              halt_q  <= 1'b0;
              phase_q <= ST_IDLE;
            end else if (!m_write) begin
              src_q <= src_nxt;
              if (lane_adv >= db) begin
                phase_q <= ST_WR;
                lane_q  <= '0;
              end else begin
                lane_q <= lane_adv;
              end
            end else begin
              dst_q <= dst_nxt;
              cnt_q <= cnt_dec;
              if (cnt_dec == '0) begin
                done_q   <= 1'b1;
                sw_run_q <= 1'b0;
                phase_q  <= ST_IDLE;
                if (ctl_q.auto_off) ctl_q.req_en <= 1'b0;
              end else if (lane_adv >= sb) begin
                phase_q <= ST_IDLE;
              end else begin
                lane_q <= lane_adv;
              end
            end
          end
        end
      endcase

      if (reg_wr_en) begin
        case (reg_sel)
          SEL_SRC: src_q <= ADDR_W'(reg_wdata);
          SEL_DST: dst_q <= ADDR_W'(reg_wdata);
          SEL_CNT: cnt_q <= CNT_W'(reg_wdata);
          default: begin
            ctl_q <= reg_wdata[8:1];
            if (reg_wdata[B_DONE]) begin
              done_q   <= 1'b0;
              berr_q   <= 1'b0;
              launch_q <= 1'b0;
              sw_run_q <= 1'b0;
              if (phase_q != ST_IDLE || launch) halt_q <= 1'b1;
            end else if (reg_wdata[B_GO] && !done_q) begin
              sw_run_q <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign irq = done_q;

  always_comb begin
    case (reg_sel)
      SEL_SRC: reg_rdata = 32'(src_q);
      SEL_DST: reg_rdata = 32'(dst_q);
      SEL_CNT: reg_rdata = 32'(cnt_q);
      default: reg_rdata = {4'b0, launch_q, (phase_q != ST_IDLE), berr_q, done_q,
                            15'b0, ctl_q, 1'b0};
    endcase
  end
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_en,
  input logic              m_valid,
  input logic              m_write,
  input logic [ADDR_W-1:0] m_addr,
  input logic [1:0]        m_size,
  input logic              m_ready,
  input logic              m_err,
  input logic              irq
);
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_size));

  p_size_legal_r12: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> m_size != 2'b11);

  p_err_done_r10: assert property (@(posedge clk) disable iff (rst)
    m_valid && m_ready && m_err && !reg_wr_en |=> irq);

  p_no_launch_r2: assert property (@(posedge clk) disable iff (rst)
    irq && !m_valid && !reg_wr_en |=> !m_valid);

  p_irq_fall_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(reg_wr_en));
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .m_valid(m_valid),
  .m_write(m_write), .m_addr(m_addr), .m_size(m_size),
  .m_ready(m_ready), .m_err(m_err), .irq(irq));

// File: tb/test_dma_xfer_engine.sv
module test_dma_xfer_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        periph_req = 1'b0;
  logic        m_valid, m_write;
  logic [31:0] m_addr;
  logic [1:0]  m_size;
  logic [31:0] m_wdata;
  logic        m_ready = 1'b0;
  logic [31:0] m_rdata = '0;
  logic        m_err = 1'b0;
  logic        irq;

  int n_chk = 0, n_err = 0;
  int n_rd = 0, n_wr = 0;
  int lat_max = 0, wcnt = 0;
  logic err_on = 1'b0;
  logic [7:0] err_addr = '0;
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  bit finished = 0;

  always #10 clk = ~clk;

  dma_xfer_engine i_dma_xfer_engine (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_size(m_size),
    .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err),
    .irq(irq));

  // bus responder: memory model, random latency, error injection
  always @(negedge clk) begin
    if (rst) begin
      m_ready = 1'b0; m_err = 1'b0;
    end else if (m_ready) begin
      m_ready = 1'b0; m_err = 1'b0;
    end else if (m_valid) begin
      if (wcnt > 0) wcnt--;
      else begin
        automatic int nb = 1 << m_size;
        automatic logic [7:0] a = m_addr[7:0];
        m_err = err_on && (a == err_addr);
        if (!m_write) begin
          m_rdata = '0;
          for (int k = 0; k < nb; k++) m_rdata[8*k +: 8] = mem[8'(a + k)];
          n_rd++;
        end else begin
          if (!m_err) for (int k = 0; k < nb; k++) mem[8'(a + k)] = m_wdata[8*k +: 8];
          n_wr++;
        end
        m_ready = 1'b1;
        wcnt = (lat_max == 0) ? 0 : int'($urandom % (lat_max + 1));
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] ctl(input bit go, input bit req, input bit aoff,
      input bit sinc, input bit dinc, input logic [1:0] ssz, input logic [1:0] dsz, input bit clr);
    return (32'(clr) << 24) | (32'(dsz) << 7) | (32'(ssz) << 5) | (32'(dinc) << 4) |
           (32'(sinc) << 3) | (32'(aoff) << 2) | (32'(req) << 1) | 32'(go);
  endfunction

  function automatic int bytes_of(input logic [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  // reference model of a full channel run on ref_mem
  task automatic model_run(input int s0, input int d0, input int cnt, input logic [1:0] ssz,
      input logic [1:0] dsz, input bit sinc, input bit dinc,
      output int s, output int d, output int nr, output int nw);
    automatic int sb = bytes_of(ssz), db = bytes_of(dsz);
    automatic int gb = (sb > db) ? sb : db;
    automatic int c = cnt;
    automatic logic [7:0] buf_b [4];
    s = s0; d = d0; nr = 0; nw = 0;
    while (c > 0) begin
      for (int r = 0; r < gb / sb; r++) begin
        for (int k = 0; k < sb; k++) buf_b[r*sb + k] = ref_mem[8'(s + k)];
        if (sinc) s += sb;
        nr++;
      end
      for (int w = 0; w < gb / db && c > 0; w++) begin
        for (int k = 0; k < db; k++) ref_mem[8'(d + k)] = buf_b[w*db + k];
        if (dinc) d += db;
        c -= db;
        nw++;
      end
    end
  endtask

  task automatic wait_irq(input int lim);
    for (int i = 0; i < lim && !irq; i++) @(negedge clk);
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'($urandom);
      ref_mem[i] = mem[i];
    end
  endtask

  task automatic cmp_mem(input string req);
    automatic int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
    chk(req, 32'(bad), 32'd0);
  endtask

  task automatic run_case(input logic [1:0] ssz, input logic [1:0] dsz, input bit sinc,
      input bit dinc, input int groups);
    automatic int sb = bytes_of(ssz), db = bytes_of(dsz);
    automatic int gb = (sb > db) ? sb : db;
    automatic int cnt = gb * groups;
    automatic int s0 = 4 * int'($urandom % 16), d0 = 128 + 4 * int'($urandom % 16);
    automatic int es, ed, enr, enw;
    automatic logic [31:0] v;
    automatic string tag = (db > sb) ? "R6" : (sb > db) ? "R7" : "R1";
    fill_mem();
    model_run(s0, d0, cnt, ssz, dsz, sinc, dinc, es, ed, enr, enw);
    wr_reg(2'd3, ctl(0, 0, 0, 0, 0, 0, 0, 1));
    wr_reg(2'd0, 32'(s0));
    wr_reg(2'd1, 32'(d0));
    wr_reg(2'd2, 32'(cnt));
    n_rd = 0; n_wr = 0;
    wr_reg(2'd3, ctl(1, 0, 0, sinc, dinc, ssz, dsz, 0));
    wait_irq(3000);
    repeat (2) @(negedge clk);
    chk({tag, " reads"}, 32'(n_rd), 32'(enr));
    chk({tag, " writes"}, 32'(n_wr), 32'(enw));
    cmp_mem({tag, " memory"});
    rd_reg(2'd0, v); chk("R3 src addr", v, 32'(es));
    rd_reg(2'd1, v); chk("R4 dst addr", v, 32'(ed));
    rd_reg(2'd2, v); chk("R5 count", v, 32'd0);
    rd_reg(2'd3, v); chk("R5 done", 32'(v[24]), 32'd1);
    chk("R1 go reads 0", 32'(v[0]), 32'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    automatic logic [31:0] v;
    automatic int snap, es, ed, enr, enw;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    for (int r = 0; r < 4; r++) begin
      rd_reg(2'(r), v); chk("R1 reset reg", v, 32'd0);
    end
    chk("R5 reset irq", 32'(irq), 32'd0);
    chk("R12 reset valid", 32'(m_valid), 32'd0);

    // directed patterns
    run_case(2'd2, 2'd0, 1, 1, 3);   // word -> bytes
    run_case(2'd0, 2'd2, 1, 1, 3);   // bytes -> word
    run_case(2'd1, 2'd1, 0, 1, 4);   // fixed source
    run_case(2'd1, 2'd2, 1, 0, 2);   // fixed destination
    run_case(2'd3, 2'd1, 1, 1, 2);   // size code 3 is word

    // R2: go ignored while done is set
    wr_reg(2'd2, 32'd8);
    n_rd = 0; n_wr = 0;
    wr_reg(2'd3, ctl(1, 0, 0, 1, 1, 0, 0, 0));
    repeat (20) @(negedge clk);
    chk("R2 no access", 32'(n_rd + n_wr), 32'd0);
    rd_reg(2'd2, v); chk("R2 count kept", v, 32'd8);

    // R5: go with zero count
    wr_reg(2'd3, ctl(0, 0, 0, 0, 0, 0, 0, 1));
    wr_reg(2'd2, 32'd0);
    n_rd = 0; n_wr = 0;
    wr_reg(2'd3, ctl(1, 0, 0, 1, 1, 0, 0, 0));
    repeat (10) @(negedge clk);
    chk("R5 zero count done", 32'(irq), 32'd1);
    chk("R5 zero count no access", 32'(n_rd + n_wr), 32'd0);

    // R8/R9: peripheral-paced transfers with auto clear
    fill_mem();
    model_run(16, 160, 12, 2'd1, 2'd2, 1, 1, es, ed, enr, enw);
    wr_reg(2'd3, ctl(0, 0, 0, 0, 0, 0, 0, 1));
    wr_reg(2'd0, 32'd16); wr_reg(2'd1, 32'd160); wr_reg(2'd2, 32'd12);
    n_rd = 0; n_wr = 0;
    wr_reg(2'd3, ctl(1, 1, 1, 1, 1, 2'd1, 2'd2, 0));
    repeat (30) @(negedge clk);
    chk("R8 waits for request", 32'(n_rd + n_wr), 32'd0);
    for (int g = 1; g <= 3; g++) begin
      @(negedge clk); periph_req = 1'b1;
      @(negedge clk); periph_req = 1'b0;
      repeat (40) @(negedge clk);
      chk("R8 reads per request", 32'(n_rd), 32'(2 * g));
      chk("R8 writes per request", 32'(n_wr), 32'(g));
      rd_reg(2'd2, v); chk("R8 count", v, 32'(12 - 4 * g));
    end
    chk("R9 done irq", 32'(irq), 32'd1);
    rd_reg(2'd3, v); chk("R9 req_en cleared", 32'(v[1]), 32'd0);
    cmp_mem("R8 memory");

    // R10/R13: bus error
    fill_mem();
    err_on = 1'b1; err_addr = 8'd43;
    wr_reg(2'd3, ctl(0, 0, 0, 0, 0, 0, 0, 1));
    wr_reg(2'd0, 32'd40); wr_reg(2'd1, 32'd200); wr_reg(2'd2, 32'd16);
    n_rd = 0; n_wr = 0;
    wr_reg(2'd3, ctl(1, 0, 0, 1, 1, 0, 0, 0));
    wait_irq(500);
    repeat (20) @(negedge clk);
    rd_reg(2'd3, v);
    chk("R10 bus_err", 32'(v[25]), 32'd1);
    chk("R10 done", 32'(v[24]), 32'd1);
    chk("R13 launched", 32'(v[27]), 32'd1);
    chk("R10 reads stop", 32'(n_rd), 32'd4);
    chk("R10 writes stop", 32'(n_wr), 32'd3);
    err_on = 1'b0;
    wr_reg(2'd3, ctl(0, 0, 0, 0, 0, 0, 0, 1));
    rd_reg(2'd3, v);
    chk("R11 clear err", 32'(v[25]), 32'd0);
    chk("R13 launched cleared", 32'(v[27]), 32'd0);
    chk("R11 irq low", 32'(irq), 32'd0);

    // R11: abort an active channel
    lat_max = 3;
    wr_reg(2'd0, 32'd0); wr_reg(2'd1, 32'd128); wr_reg(2'd2, 32'd40);
    n_rd = 0; n_wr = 0;
    wr_reg(2'd3, ctl(1, 0, 0, 1, 1, 0, 0, 0));
    for (int i = 0; i < 500 && n_wr < 3; i++) @(negedge clk);
    wr_reg(2'd3, ctl(0, 0, 0, 1, 1, 0, 0, 1));
    repeat (10) @(negedge clk);
    snap = n_rd + n_wr;
    repeat (30) @(negedge clk);
    chk("R11 accesses stop", 32'(n_rd + n_wr), 32'(snap));
    rd_reg(2'd3, v);
    chk("R11 not busy", 32'(v[26]), 32'd0);
    chk("R11 done clear", 32'(v[24]), 32'd0);
    rd_reg(2'd2, v);
    chk("R11 count left", 32'(v != 0), 32'd1);

    // constrained random runs
    for (int t = 0; t < 40; t++) begin
      lat_max = int'($urandom % 3);
      run_case(2'($urandom % 3), 2'($urandom % 3), 1'($urandom), 1'($urandom),
               1 + int'($urandom % 6));
    end
    finish_run();
  end
endmodule